// File: doc/BRIEF.md
# Iterative ARX Block Encryption Engine

This block encrypts one 64-bit block under a 128-bit key using an add-rotate-xor round built from 32-bit modular addition, fixed rotations and XOR. It works iteratively: after a single load cycle, each clock performs one data round and one key-schedule step. The key schedule runs through the same round logic as the data path. In the key schedule the round counter takes the place of the round key. The expanded key is therefore never stored; only the current round key and three pending schedule words are held.

A host applies plaintext and key and raises `start_i` for a cycle while the engine is idle. Twenty-seven rounds later, `done_o` pulses for one cycle and the ciphertext appears on `ct_o`. The ciphertext stays there until the next start is accepted. A new start may be given in the same cycle that `done_o` is high, so blocks can run back to back with no idle cycle between them.

Top module: `arx_block_enc`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first accepted start, `done_o` is 0 and `ct_o` is all zeros.
- R2: On a start accepted while idle, the word x is taken from `pt_i[63:32]` and the word y from `pt_i[31:0]`. The round key k0 is taken from `key_i[31:0]`, and the schedule words l0, l1 and l2 from `key_i[63:32]`, `key_i[95:64]` and `key_i[127:96]`. The result is presented as `ct_o = {x, y}`.
- R3: Each data round with round key k computes x = (rotr(x,8) + y mod 2^32) XOR k, then y = rotl(y,3) XOR x, using the new x. Rounds 0 to 26 are applied.
- R4: The round key for round i is k_i. The schedule computes l_{i+3} = (k_i + rotr(l_i,8)) XOR i and k_{i+1} = rotl(k_i,3) XOR l_{i+3}, where i is the round counter, zero-extended to 32 bits.
- R5: `done_o` rises exactly 27 rising edges after the edge that samples an accepted `start_i`. That is the cycle after the edge that writes round 26.
- R6: `done_o` is high for exactly one cycle per encryption.
- R7: After `done_o`, `ct_o` holds its value while no start is accepted, whatever `pt_i` and `key_i` do.
- R8: `start_i` raised while an encryption is running is ignored. The running result and its timing are unchanged.
- R9: A start raised in the cycle `done_o` is high is accepted. The new result follows 27 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an encryption; sampled only while idle |
| pt_i | input | 64 | Plaintext block |
| key_i | input | 128 | Cipher key |
| ct_o | output | 64 | Ciphertext, valid from `done_o` until the next accepted start |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Random keys and plaintexts from a fixed seed are compared against a bench model of the cipher. Any error in rotation amount, carry, counter constant or schedule-word order spreads over 27 rounds into a wrong ciphertext. A fixed published-style vector with byte-patterned words checks the mapping of fields in R2, which random data alone would not catch if words were swapped symmetrically. Directed sequences check the remaining behaviour. A start raised mid-run must not restart the engine or change the result. A start in the done cycle must be accepted without a gap. Input changes after completion must leave `ct_o` and `done_o` untouched.

// File: rtl/arx_pkg.sv
package arx_pkg;
  // rotation amounts depend only on word size
  function automatic int unsigned rot_a(input int unsigned w);
    return (w == 16) ? 7 : 8;
  endfunction

  function automatic int unsigned rot_b(input int unsigned w);
    return (w == 16) ? 2 : 3;
  endfunction
endpackage

// File: rtl/arx_round.sv
module arx_round #(
  parameter int unsigned W  = 32,
  parameter int unsigned RA = 8,
  parameter int unsigned RB = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] k_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic [W-1:0] x_rot, y_rot, x_new;

  assign x_rot = (x_i >> RA) | (x_i << (W - RA));
  assign y_rot = (y_i << RB) | (y_i >> (W - RB));
  assign x_new = (x_rot + y_i) ^ k_i;
  assign x_o   = x_new;
  assign y_o   = y_rot ^ x_new;
endmodule

// File: rtl/arx_key_sched.sv
module arx_key_sched #(
  parameter int unsigned W     = 32,
  parameter int unsigned KW    = 4,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned RA    = 8,
  parameter int unsigned RB    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [W*KW-1:0] key_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [W-1:0]    rk_o
);
  localparam int unsigned LD = KW - 1;

  logic [W-1:0] k_q;
  logic [W-1:0] l_q [LD];
  logic [W-1:0] l_nxt, k_nxt, rc;

  assign rc = {{(W-CNT_W){1'b0}}, cnt_i};

  // schedule step reuses the data round, counter as round key
  arx_round #(.W(W), .RA(RA), .RB(RB)) u_ks_round (
    .x_i(l_q[0]),
    .y_i(k_q),
    .k_i(rc),
    .x_o(l_nxt),
    .y_o(k_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     k_q <= '0;
    else if (load_i) k_q <= key_i[W-1:0];
    else if (step_i) k_q <= k_nxt;
  end

  // l ring: read slot 0, write newest word into top slot
  for (genvar j = 0; j < LD; j++) begin : g_lring
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     l_q[j] <= '0;
      else if (load_i) l_q[j] <= key_i[(j+1)*W +: W];
      else if (step_i) begin
        if (j == LD - 1) l_q[j] <= l_nxt;
        else             l_q[j] <= l_q[(j+1) % LD];
      end
    end
  end

  assign rk_o = k_q;
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl #(
  parameter int unsigned ROUNDS = 27,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic             busy_q, done_q, last;
  logic [CNT_W-1:0] cnt_q;

  assign last   = busy_q && (cnt_q == CNT_W'(ROUNDS - 1));
  assign load_o = start_i && !busy_q;
  assign step_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (load_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/arx_block_enc.sv
module arx_block_enc #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned KEY_WORDS = 4,
  parameter int unsigned ROUNDS    = 27
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [2*WORD_W-1:0]           pt_i,
  input  logic [KEY_WORDS*WORD_W-1:0]   key_i,
  output logic [2*WORD_W-1:0]           ct_o,
  output logic                          done_o
);
  import arx_pkg::*;

  localparam int unsigned BLK_W = 2 * WORD_W;
  localparam int unsigned CNT_W = $clog2(ROUNDS + 1);
  localparam int unsigned RA    = rot_a(WORD_W);
  localparam int unsigned RB    = rot_b(WORD_W);

  logic              load, busy;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] x_q, y_q, x_nxt, y_nxt, rk;

  arx_ctrl #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (busy),
    .cnt_o  (cnt),
    .done_o (done_o)
  );

  arx_key_sched #(.W(WORD_W), .KW(KEY_WORDS), .CNT_W(CNT_W), .RA(RA), .RB(RB)) u_ks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (busy),
    .key_i  (key_i),
    .cnt_i  (cnt),
    .rk_o   (rk)
  );

  arx_round #(.W(WORD_W), .RA(RA), .RB(RB)) u_data_round (
    .x_i(x_q),
    .y_i(y_q),
    .k_i(rk),
    .x_o(x_nxt),
    .y_o(y_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= pt_i[BLK_W-1:WORD_W];
      y_q <= pt_i[WORD_W-1:0];
    end else if (busy) begin
      x_q <= x_nxt;
      y_q <= y_nxt;
    end
  end

  assign ct_o = {x_q, y_q};
endmodule

// File: rtl/arx_block_enc_chk.sv
module arx_block_enc_chk #(
  parameter int unsigned ROUNDS = 27,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned BLK_W  = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             done_o,
  input logic [BLK_W-1:0] ct_o,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy) && $past(cnt) == CNT_W'(ROUNDS - 1) && !busy));

  // R7
  ct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(ct_o));

  // R8
  busy_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt != CNT_W'(ROUNDS - 1)) |=> (busy && cnt == $past(cnt) + 1'b1));

  // R9
  load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (busy && cnt == '0));
endmodule

bind arx_block_enc arx_block_enc_chk #(.ROUNDS(ROUNDS), .CNT_W(CNT_W), .BLK_W(BLK_W)) u_chk (.*);

// File: tb/sim_arx_block_enc.sv
module sim_arx_block_enc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  pt = '0;
  logic [127:0] key = '0;
  logic [63:0]  ct;
  logic         done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  arx_block_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pt_i(pt), .key_i(key), .ct_o(ct), .done_o(done)
  );

  function automatic logic [31:0] rr8(input logic [31:0] v);
    return {v[7:0], v[31:8]};
  endfunction

  function automatic logic [31:0] rl3(input logic [31:0] v);
    return {v[28:0], v[31:29]};
  endfunction

  function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [127:0] kk);
    logic [31:0] x, y, k;
    logic [31:0] l [0:29];
    x = p[63:32]; y = p[31:0];
    k = kk[31:0];
    l[0] = kk[63:32]; l[1] = kk[95:64]; l[2] = kk[127:96];
    for (int i = 0; i < 27; i++) begin
      x = (rr8(x) + y) ^ k;
      y = rl3(y) ^ x;
      l[i+3] = (k + rr8(l[i])) ^ 32'(i);
      k = rl3(k) ^ l[i+3];
    end
    return {x, y};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // b2b: inputs driven in the current (done) cycle without waiting a cycle
  task automatic run_enc(input logic [63:0] p, input logic [127:0] kk, input bit b2b, input bit poke);
    int lat;
    logic [63:0] exp;
    exp = ref_enc(p, kk);
    if (!b2b) @(negedge clk);
    pt = p; key = kk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 5) begin
        start = 1'b1; pt = {$urandom, $urandom}; key = {$urandom, $urandom, $urandom, $urandom};
      end
      if (poke && lat == 7) start = 1'b0;
    end
    check(lat == 27, poke ? "R8 latency with mid-run start" : (b2b ? "R9 latency" : "R5 latency"),
          64'(lat), 64'd27);
    check(ct == exp, poke ? "R8 ciphertext with mid-run start" :
          (b2b ? "R9 back-to-back ciphertext" : "R2/R3/R4 ciphertext"), ct, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1 in reset
    check(done == 1'b0 && ct == '0, "R1 reset", {ct[62:0], done}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && ct == '0, "R1 after release", {ct[62:0], done}, 64'd0);

    // R2 field order with patterned words
    run_enc(64'h3b726574_7475432d, 128'h1b1a1918_13121110_0b0a0908_03020100, 0, 0);
    check(ct == 64'h8c6fa548_454e028b, "R2 known vector", ct, 64'h8c6fa548_454e028b);

    // corner values
    run_enc('0, '0, 0, 0);
    run_enc('1, '1, 0, 0);
    run_enc(64'h8000_0000_0000_0001, 128'h1, 0, 0);

    // random
    for (int v = 0; v < 40; v++)
      run_enc({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 0, 0);

    // R8 start while busy
    for (int v = 0; v < 3; v++)
      run_enc({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 0, 1);

    // R9 back to back chain
    run_enc({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 0, 0);
    for (int v = 0; v < 4; v++)
      run_enc({$urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom}, 1, 0);

    // R6 / R7 hold after done
    held = ct;
    for (int c = 0; c < 6; c++) begin
      pt = {$urandom, $urandom}; key = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
      check(done == 1'b0, "R6 done single cycle", 64'(done), 64'd0);
      check(ct == held, "R7 ciphertext held", ct, held);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule